// File: doc/BRIEF.md
# Split Instruction/Data Translation Lookaside Hierarchy

This block turns 32-bit virtual addresses from an instruction-fetch port and a data-access port into physical addresses. Each port has its own small fully associative micro TLB. Behind the two micro TLBs sits one larger shared main TLB. When a request misses its micro TLB, the request asks the shared main TLB. When a request also misses the main TLB, the block raises a request on a walk port to an external page-table walker. The walker's response fills the main TLB and the micro TLB of the port that asked for it, and the response also completes that request.

A mapping can be a 4 KB page, a 16 KB page, a 1 MB section or a 16 MB section. All four sizes live side by side in every array. The size is stored with each entry, and the tag match ignores the page-number bits that the size puts inside the offset. A flush input clears all three arrays at once. A requester holds its request and address steady until it sees a one-cycle acknowledge with the physical address. It then drops the request or presents a new one.

Top module: `xlat_tlb2`

## Requirements
- R1: While reset is high and in the cycle after it, `i_ack`, `d_ack` and `walk_req` are low.
- R2: A request that hits its own micro TLB is acknowledged on the first clock edge after the request is first sampled, so the latency is 1 cycle, with the translated physical address.
- R3: A request that misses its micro TLB but hits the main TLB is acknowledged with a latency of 2 cycles, and the mapping is copied into that port's micro TLB, so the next access to the same page has a latency of 1.
- R4: A request that misses both levels raises `walk_req` with `walk_va` equal to the request address and `walk_for_data` = 1 for the data port or 0 for the instruction port. The walk outputs stay steady until `walk_rsp_valid`, and the request is then acknowledged with the address formed from the response.
- R5: A walk fill is written into the main TLB and into the requesting port's micro TLB only. The other port's first access to that page has a latency of 2.
- R6: `walk_rsp_size` codes are 0 for 4 KB, 1 for 16 KB, 2 for 1 MB and 3 for 16 MB. These sizes keep 12, 14, 20 or 24 low bits of the virtual address, and the higher bits come from `walk_rsp_ppn` (a 20-bit frame number in bits 31:12). The tag match ignores the same bits, so any address inside a filled mapping hits and an address outside it does not.
- R7: When both ports are waiting for the main TLB in the same cycle, the data port is served first and the instruction port one cycle later.
- R8: At most one walk is outstanding. A port that misses the main TLB while a walk is pending keeps retrying the main TLB, and it walks only if the retry still misses after the fill. `walk_req` is low in the cycle after a response.
- R9: A flush pulse invalidates every entry of all three arrays in one cycle, so a page that hit before the flush needs a new walk.
- R10: Each array replaces its entries in round-robin order. A micro TLB of depth N that has received N+1 fills no longer holds the first one, but the main TLB still does.
- R11: Each request gets exactly one single-cycle acknowledge, and an acknowledge is never given without a request in the cycle before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all entries |
| i_req | input | 1 | Instruction translation request, held until acknowledged |
| i_va | input | 32 | Instruction virtual address |
| i_ack | output | 1 | Instruction translation done (one cycle) |
| i_pa | output | 32 | Instruction physical address, valid with `i_ack` |
| d_req | input | 1 | Data translation request, held until acknowledged |
| d_va | input | 32 | Data virtual address |
| d_ack | output | 1 | Data translation done (one cycle) |
| d_pa | output | 32 | Data physical address, valid with `d_ack` |
| walk_req | output | 1 | Page-table walk request, held until the response |
| walk_va | output | 32 | Virtual address to walk |
| walk_for_data | output | 1 | 1 if the walk serves the data port |
| walk_rsp_valid | input | 1 | Walk response strobe |
| walk_rsp_ppn | input | 20 | Frame number from the walk |
| walk_rsp_size | input | 2 | Mapping size code of the walk result |

## Verification
The hardest case to reach is both micro TLBs missing in the same cycle on the same page while the main TLB also misses. In that case the data port must walk and the instruction port must keep retrying until the fill lands, then hit the main TLB without a second walk. The bench reaches this case by flushing, then starting two forked drivers on the same falling edge. A second hard case is a mapping that sits in the main TLB but in neither micro TLB. The bench creates it by overfilling the data micro TLB until the round-robin victim pointer evicts the target page. It then sends both ports at that page together to observe the arbitration order.

// File: rtl/tlbh_pkg.sv
package tlbh_pkg;

  localparam int VA_W   = 32;
  localparam int OFS_W  = 12;
  localparam int VPN_W  = VA_W - OFS_W;

  typedef enum logic [1:0] {
    SZ_4K  = 2'd0,
    SZ_16K = 2'd1,
    SZ_1M  = 2'd2,
    SZ_16M = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic             vld;
    pg_size_e         size;
    logic [VPN_W-1:0] vpn;
    logic [VPN_W-1:0] ppn;
  } tlb_ent_t;

  // Page-number bits that belong to the in-page offset for a size.
  function automatic logic [VPN_W-1:0] keep_mask(input pg_size_e s);
    case (s)
      SZ_16K:  return VPN_W'(20'h00003);
      SZ_1M:   return VPN_W'(20'h000FF);
      SZ_16M:  return VPN_W'(20'h00FFF);
      default: return '0;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] form_pa(input logic [VPN_W-1:0] ppn,
                                              input pg_size_e          s,
                                              input logic [VA_W-1:0]   va);
    logic [VPN_W-1:0] m;
    m = keep_mask(s);
    return {(ppn & ~m) | (va[VA_W-1:OFS_W] & m), va[OFS_W-1:0]};
  endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
  import tlbh_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [VA_W-1:0]  lk_va,
  output logic             lk_hit,
  output logic [VPN_W-1:0] lk_ppn,
  output pg_size_e         lk_size,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [VPN_W-1:0] wr_ppn,
  input  pg_size_e         wr_size
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  tlb_ent_t         ent [DEPTH];
  logic [DEPTH-1:0] hitv;
  logic [IW-1:0]    victim;

  // Size-masked tag compare per entry.
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hitv[g] = ent[g].vld &&
      (((ent[g].vpn ^ lk_va[VA_W-1:OFS_W]) & ~keep_mask(ent[g].size)) == '0);
  end

  // Lowest matching index wins.
  always_comb begin
    lk_hit  = 1'b0;
    lk_ppn  = '0;
    lk_size = SZ_4K;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hitv[k]) begin
        lk_hit  = 1'b1;
        lk_ppn  = ent[k].ppn;
        lk_size = ent[k].size;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      victim <= '0;
      for (int k = 0; k < DEPTH; k++) ent[k] <= '0;
    end else begin
      if (wr_en) begin
        ent[victim] <= tlb_ent_t'{vld: 1'b1, size: wr_size, vpn: wr_vpn, ppn: wr_ppn};
        victim      <= (victim == IW'(DEPTH - 1)) ? '0 : victim + 1'b1;
      end
      if (flush) begin
        for (int k = 0; k < DEPTH; k++) ent[k].vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/tlb_port_ctl.sv
module tlb_port_ctl
  import tlbh_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [VA_W-1:0]  va,
  input  logic             u_hit,
  input  logic [VPN_W-1:0] u_ppn,
  input  pg_size_e         u_size,
  input  logic             grant,
  input  logic             m_hit,
  input  logic [VPN_W-1:0] m_ppn,
  input  pg_size_e         m_size,
  input  logic             walk_free,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_ppn,
  input  pg_size_e         fill_size,
  output logic             ack,
  output logic [VA_W-1:0]  pa,
  output logic             want_main,
  output logic             walk_start,
  output logic             u_wr_en,
  output logic [VPN_W-1:0] u_wr_ppn,
  output pg_size_e         u_wr_size
);

  typedef enum logic [1:0] {PS_IDLE, PS_MAIN, PS_WALK} pst_e;
  pst_e st;

  logic main_take;
  logic walk_take;

  assign want_main  = (st == PS_MAIN);
  assign main_take  = want_main && grant && m_hit;
  assign walk_start = want_main && grant && !m_hit && walk_free;
  assign walk_take  = (st == PS_WALK) && fill_en;

  // Refill of the own micro array, from the main array or from a walk.
  always_comb begin
    u_wr_en   = main_take || walk_take;
    u_wr_ppn  = main_take ? m_ppn  : fill_ppn;
    u_wr_size = main_take ? m_size : fill_size;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= PS_IDLE;
      ack <= 1'b0;
      pa  <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        PS_IDLE: begin
          if (req) begin
            if (u_hit) begin
              ack <= 1'b1;
              pa  <= form_pa(u_ppn, u_size, va);
            end else begin
              st <= PS_MAIN;
            end
          end
        end
        PS_MAIN: begin
          if (main_take) begin
            ack <= 1'b1;
            pa  <= form_pa(m_ppn, m_size, va);
            st  <= PS_IDLE;
          end else if (walk_start) begin
            st <= PS_WALK;
          end
        end
        PS_WALK: begin
          if (walk_take) begin
            ack <= 1'b1;
            pa  <= form_pa(fill_ppn, fill_size, va);
            st  <= PS_IDLE;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xlat_tlb2.sv
module xlat_tlb2
  import tlbh_pkg::*;
#(
  parameter int I_DEPTH = 4,
  parameter int D_DEPTH = 4,
  parameter int M_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        i_req,
  input  logic [31:0] i_va,
  output logic        i_ack,
  output logic [31:0] i_pa,
  input  logic        d_req,
  input  logic [31:0] d_va,
  output logic        d_ack,
  output logic [31:0] d_pa,
  output logic        walk_req,
  output logic [31:0] walk_va,
  output logic        walk_for_data,
  input  logic        walk_rsp_valid,
  input  logic [19:0] walk_rsp_ppn,
  input  logic [1:0]  walk_rsp_size
);

  localparam int NP = 2;  // index 0: instruction, 1: data

  logic [NP-1:0]    p_req, p_ack, want, grant, w_start, fill_en, u_hit, u_wr_en;
  logic [VA_W-1:0]  p_va [NP];
  logic [VA_W-1:0]  p_pa [NP];
  logic [VPN_W-1:0] u_ppn [NP];
  logic [VPN_W-1:0] u_wr_ppn [NP];
  pg_size_e         u_size [NP];
  pg_size_e         u_wr_size [NP];

  logic             m_hit;
  logic [VPN_W-1:0] m_ppn;
  pg_size_e         m_size;
  logic [VA_W-1:0]  m_va;
  logic             m_wr_en;
  pg_size_e         rsp_size;

  logic             busy;
  logic             owner;
  logic [VA_W-1:0]  wva;

  assign p_req   = {d_req, i_req};
  assign p_va[0] = i_va;
  assign p_va[1] = d_va;
  assign i_ack   = p_ack[0];
  assign d_ack   = p_ack[1];
  assign i_pa    = p_pa[0];
  assign d_pa    = p_pa[1];

  // Fixed priority for the shared array: data before instruction.
  assign grant[1] = want[1];
  assign grant[0] = want[0] && !want[1];
  assign m_va     = grant[1] ? p_va[1] : p_va[0];

  assign rsp_size = pg_size_e'(walk_rsp_size);
  assign m_wr_en  = busy && walk_rsp_valid;
  assign fill_en  = {m_wr_en && owner, m_wr_en && !owner};

  for (genvar g = 0; g < NP; g++) begin : g_side
    localparam int UD = (g == 0) ? I_DEPTH : D_DEPTH;

    tlb_cam #(.DEPTH(UD)) u_micro (
      .clk     (clk),
      .rst     (rst),
      .flush   (flush),
      .lk_va   (p_va[g]),
      .lk_hit  (u_hit[g]),
      .lk_ppn  (u_ppn[g]),
      .lk_size (u_size[g]),
      .wr_en   (u_wr_en[g]),
      .wr_vpn  (p_va[g][VA_W-1:OFS_W]),
      .wr_ppn  (u_wr_ppn[g]),
      .wr_size (u_wr_size[g])
    );

    tlb_port_ctl u_ctl (
      .clk        (clk),
      .rst        (rst),
      .req        (p_req[g]),
      .va         (p_va[g]),
      .u_hit      (u_hit[g]),
      .u_ppn      (u_ppn[g]),
      .u_size     (u_size[g]),
      .grant      (grant[g]),
      .m_hit      (m_hit),
      .m_ppn      (m_ppn),
      .m_size     (m_size),
      .walk_free  (!busy),
      .fill_en    (fill_en[g]),
      .fill_ppn   (walk_rsp_ppn),
      .fill_size  (rsp_size),
      .ack        (p_ack[g]),
      .pa         (p_pa[g]),
      .want_main  (want[g]),
      .walk_start (w_start[g]),
      .u_wr_en    (u_wr_en[g]),
      .u_wr_ppn   (u_wr_ppn[g]),
      .u_wr_size  (u_wr_size[g])
    );
  end

  tlb_cam #(.DEPTH(M_DEPTH)) u_main (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_va   (m_va),
    .lk_hit  (m_hit),
    .lk_ppn  (m_ppn),
    .lk_size (m_size),
    .wr_en   (m_wr_en),
    .wr_vpn  (wva[VA_W-1:OFS_W]),
    .wr_ppn  (walk_rsp_ppn),
    .wr_size (rsp_size)
  );

  // Single outstanding walk.
  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      owner <= 1'b0;
      wva   <= '0;
    end else if (busy) begin
      if (walk_rsp_valid) busy <= 1'b0;
    end else if (|w_start) begin
      busy  <= 1'b1;
      owner <= w_start[1];
      wva   <= w_start[1] ? p_va[1] : p_va[0];
    end
  end

  assign walk_req      = busy;
  assign walk_va       = wva;
  assign walk_for_data = owner;

endmodule

// File: rtl/xlat_tlb2_chk.sv
module xlat_tlb2_chk (
  input logic        clk,
  input logic        rst,
  input logic        i_req,
  input logic        i_ack,
  input logic        d_req,
  input logic        d_ack,
  input logic        walk_req,
  input logic [31:0] walk_va,
  input logic        walk_for_data,
  input logic        walk_rsp_valid
);

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    rst |=> (!i_ack && !d_ack && !walk_req));

  // R4
  walk_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && !walk_rsp_valid) |=>
      (walk_req && $stable(walk_va) && $stable(walk_for_data)));

  // R8
  one_walk_chk: assert property (@(posedge clk) disable iff (rst)
    (walk_req && walk_rsp_valid) |=> !walk_req);

  // R11
  i_ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    i_ack |-> $past(i_req));

  // R11
  d_ack_req_chk: assert property (@(posedge clk) disable iff (rst)
    d_ack |-> $past(d_req));

endmodule

bind xlat_tlb2 xlat_tlb2_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .i_req         (i_req),
  .i_ack         (i_ack),
  .d_req         (d_req),
  .d_ack         (d_ack),
  .walk_req      (walk_req),
  .walk_va       (walk_va),
  .walk_for_data (walk_for_data),
  .walk_rsp_valid(walk_rsp_valid)
);

// File: tb/test_xlat_tlb2.sv
`timescale 1ns/1ps
module test_xlat_tlb2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        i_req = 1'b0, d_req = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic        i_ack, d_ack;
  logic [31:0] i_pa, d_pa;
  logic        walk_req, walk_for_data;
  logic [31:0] walk_va;
  logic        walk_rsp_valid = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [1:0]  walk_rsp_size = '0;

  always #2 clk = ~clk;

  xlat_tlb2 i_xlat_tlb2 (
    .clk(clk), .rst(rst), .flush(flush),
    .i_req(i_req), .i_va(i_va), .i_ack(i_ack), .i_pa(i_pa),
    .d_req(d_req), .d_va(d_va), .d_ack(d_ack), .d_pa(d_pa),
    .walk_req(walk_req), .walk_va(walk_va), .walk_for_data(walk_for_data),
    .walk_rsp_valid(walk_rsp_valid), .walk_rsp_ppn(walk_rsp_ppn),
    .walk_rsp_size(walk_rsp_size)
  );

  typedef struct {
    logic [31:0] pa;
    int          lat;
    string       tag;
  } exp_t;

  exp_t        q_i[$];
  exp_t        q_d[$];
  int          nchk = 0, nbad = 0;
  int          cyc = 0;
  int          start_c[2];
  int          done_c[2];
  int          last_done[2];
  int          nwalk = 0;
  logic [31:0] last_wva = '0;
  logic        last_wdata = 1'b0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  // Independent page model used by the walker and for expected addresses.
  function automatic void ref_map(input logic [31:0] va,
                                  output logic [19:0] ppn, output logic [1:0] sz);
    if (va[31:24] == 8'h40)        begin sz = 2'd3; ppn = 20'hA5123; end
    else if (va[31:20] == 12'h123) begin sz = 2'd2; ppn = 20'h789AB; end
    else if (va[31:24] == 8'h10)   begin sz = 2'd1; ppn = va[31:12] ^ 20'h0C0C3; end
    else                           begin sz = 2'd0; ppn = va[31:12] ^ 20'hF0F0F; end
  endfunction

  function automatic logic [31:0] ref_pa(input logic [31:0] va);
    logic [19:0] ppn;
    logic [1:0]  sz;
    int          ob;
    logic [31:0] m;
    ref_map(va, ppn, sz);
    ob = (sz == 2'd0) ? 12 : (sz == 2'd1) ? 14 : (sz == 2'd2) ? 20 : 24;
    m  = (32'h1 << ob) - 32'h1;
    return ({ppn, 12'h000} & ~m) | (va & m);
  endfunction

  // Driver: push expectation, present request, wait for completion.
  task automatic access(input int port, input logic [31:0] va,
                        input int lat, input string tag);
    exp_t e;
    int   n0;
    e.pa = ref_pa(va); e.lat = lat; e.tag = tag;
    if (port == 0) q_i.push_back(e); else q_d.push_back(e);
    n0 = done_c[port];
    @(negedge clk);
    if (port == 0) begin i_req = 1'b1; i_va = va; end
    else           begin d_req = 1'b1; d_va = va; end
    start_c[port] = cyc;
    wait (done_c[port] == n0 + 1);
    @(negedge clk);
    if (port == 0) i_req = 1'b0; else d_req = 1'b0;
  endtask

  task automatic take(input int port, input logic [31:0] pa);
    exp_t e;
    int   qn;
    qn = (port == 0) ? q_i.size() : q_d.size();
    check(qn != 0, "R11 ack without pending request", pa, 32'h0);
    if (qn != 0) begin
      e = (port == 0) ? q_i.pop_front() : q_d.pop_front();
      check(pa == e.pa, e.tag, pa, e.pa);
      if (e.lat > 0)
        check(cyc - start_c[port] == e.lat, {e.tag, " latency"},
              32'(cyc - start_c[port]), 32'(e.lat));
      last_done[port] = cyc;
      done_c[port]++;
    end
  endtask

  // Monitor
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      if (!rst) begin
        if (i_ack) take(0, i_pa);
        if (d_ack) take(1, d_pa);
      end
    end
  end

  // Walker model
  initial begin
    logic [19:0] p;
    logic [1:0]  s;
    forever begin
      @(negedge clk);
      if (walk_req && !rst) begin
        nwalk++;
        last_wva   = walk_va;
        last_wdata = walk_for_data;
        repeat (3) @(negedge clk);
        ref_map(walk_va, p, s);
        walk_rsp_ppn   = p;
        walk_rsp_size  = s;
        walk_rsp_valid = 1'b1;
        @(negedge clk);
        walk_rsp_valid = 1'b0;
      end
    end
  end

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    nchk++; nbad++;
    $display("FAIL watchdog expired act=%0d exp=0", cyc);
    finish_run();
  end

  task automatic do_flush;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  initial begin
    int w;
    done_c = '{0, 0}; start_c = '{0, 0}; last_done = '{0, 0};
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!i_ack && !d_ack && !walk_req, "R1 reset outputs quiet",
          {29'h0, i_ack, d_ack, walk_req}, 32'h0);
    rst = 1'b0;

    // Walk path, then micro hit, other side via main, copy to micro
    w = nwalk;
    access(0, 32'h0000_5123, 0, "R4 walk fill result");
    check(nwalk == w + 1, "R4 one walk issued", 32'(nwalk), 32'(w + 1));
    check(last_wva == 32'h0000_5123, "R4 walk address", last_wva, 32'h0000_5123);
    check(last_wdata == 1'b0, "R4 instruction walk flag", 32'(last_wdata), 32'h0);
    access(0, 32'h0000_5FFC, 1, "R2 micro hit");
    access(1, 32'h0000_5010, 2, "R5 data side via main");
    access(1, 32'h0000_5020, 1, "R3 copied into data micro");

    // Sizes
    access(0, 32'h1234_5678, 0, "R6 1M section walk");
    access(0, 32'h123F_0004, 1, "R6 1M section hit");
    access(1, 32'h40AB_CDEF, 0, "R6 16M section walk");
    check(last_wdata == 1'b1, "R4 data walk flag", 32'(last_wdata), 32'h1);
    access(1, 32'h4012_3456, 1, "R6 16M section hit");
    access(1, 32'h1000_4ABC, 0, "R6 16K page walk");
    access(1, 32'h1000_7FF0, 1, "R6 16K page hit");
    w = nwalk;
    access(1, 32'h1000_8000, 0, "R6 next 16K page");
    check(nwalk == w + 1, "R6 outside mapping walks", 32'(nwalk), 32'(w + 1));

    // Flush
    do_flush();
    w = nwalk;
    access(0, 32'h0000_5123, 0, "R9 after flush");
    check(nwalk == w + 1, "R9 flush forces walk", 32'(nwalk), 32'(w + 1));

    // Round-robin eviction and arbitration
    do_flush();
    for (int k = 0; k < 5; k++)
      access(1, 32'h0060_0000 + 32'(k) * 32'h1000, 0, "R10 fill");
    access(1, 32'h0060_0000, 2, "R10 evicted from micro, kept in main");
    fork
      access(0, 32'h0060_1008, 3, "R7 instruction waits");
      access(1, 32'h0060_1004, 2, "R7 data served first");
    join

    // Both miss both levels on one page
    do_flush();
    w = nwalk;
    fork
      access(0, 32'h0077_7000, 0, "R8 instruction after fill");
      access(1, 32'h0077_7004, 0, "R8 data walks");
    join
    check(nwalk == w + 1, "R8 single walk", 32'(nwalk), 32'(w + 1));
    check(last_wdata == 1'b1, "R7 data owns walk", 32'(last_wdata), 32'h1);
    check(last_done[0] > last_done[1], "R8 instruction completes later",
          32'(last_done[0]), 32'(last_done[1] + 1));

    repeat (4) @(negedge clk);
    check(q_i.size() == 0 && q_d.size() == 0, "R11 all requests answered",
          32'(q_i.size() + q_d.size()), 32'h0);
    finish_run();
  end

endmodule